// File: doc/BRIEF.md
# USB Frame Timer with Done-Queue Interrupt Delay

This block paces the frame schedule of a USB host controller. A 12 MHz bit-time tick drives a down-counter that is loaded with a programmable frame interval. When the counter has run out and one more tick arrives in the operational state, a frame boundary occurs. At each boundary the block emits a start-of-frame pulse, advances a 16-bit frame number and copies the interval toggle into the remaining-time toggle.

The same boundaries step a small delay counter. This counter decides when the list of completed transfers is reported to software. Each completed transfer can shorten the delay to its own 3-bit minimum. When the delay has run out and no earlier report is still pending, the block asks for a done-head writeback. It also supplies the head value to write, with bit 0 flagged when an enabled interrupt is pending.

Software reaches the interval, remaining-time, frame-number, periodic-start and low-speed-threshold values through a simple write strobe and a combinational read port. Register selects: 0 interval, 1 remaining, 2 frame number, 3 periodic start, 4 low-speed threshold.

Top module: `usb_frame_clock`

## Requirements
- R1: After reset the interval reads 0x27782EDF (interval 0x2EDF, max packet 0x2778, toggle 0). The low-speed threshold reads 0x00000628. The frame number, periodic start and remaining values read 0.
- R2: A write to select 0 stores the interval from bits 13:0, the max-packet field from bits 30:16 and the toggle from bit 31. Bits 15:14 read back as 0.
- R3: Select 1 reads the remaining toggle in bit 31 and the remaining count in bits 13:0 while `run_en` is high. While `run_en` is low it reads only the toggle. Writes to selects 1 and 2 change nothing.
- R4: The remaining count is loaded with the interval at every start of frame. It drops by one on each `bit_tick` and holds at zero without wrapping.
- R5: A frame boundary occurs when `run_en`, `bit_tick` and a zero remaining count coincide. On the next cycle `sof_pulse` is high, the frame number has advanced by one (0xFFFF wraps to 0), and the remaining toggle equals the interval toggle.
- R6: The delay counter starts at 7. A completed transfer lowers it to that transfer's delay value only when the value is smaller.
- R7: At a boundary where the delay counter is 0 and `wb_irq_pend` is low, `wb_req` pulses together with `sof_pulse` and the counter reloads to 7. While `wb_irq_pend` is high the counter stays 0 and no request is made.
- R8: When `wb_req` pulses, `wb_head` holds `done_head` with bit 0 set if `irq_any` was high at the boundary.
- R9: After the writeback decision, each boundary lowers the delay counter by one unless it is 7 or 0.
- R10: Writes to selects 3 and 4 keep only bits 15:0. The upper bits read as 0.
- R11: A rising `run_en` starts a frame: `sof_pulse` on the next cycle and the count reloaded, with the frame number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per USB bit time |
| run_en | input | 1 | Operational state active |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| xfer_done | input | 1 | A transfer completed this cycle |
| xfer_delay | input | 3 | Minimum report delay of that transfer, in frames |
| wb_irq_pend | input | 1 | Writeback interrupt still pending |
| irq_any | input | 1 | Some enabled interrupt is pending |
| done_head | input | 32 | Current head of the completed-transfer list |
| sof_pulse | output | 1 | Start-of-frame pulse |
| wb_req | output | 1 | Done-head writeback request |
| wb_head | output | 32 | Value to write back as the done head |

## Verification
A wrong remaining count appears on the remaining-time read within one tick. It also shifts every later `sof_pulse` by the same amount, so one frame is enough to expose it. A corrupted frame number or toggle appears on the next read after the boundary that caused it. The delay counter cannot be read, so a wrong value shows only as `wb_req` arriving on the wrong `sof_pulse`. That takes up to eight frames, so the bench counts boundaries after each completed-transfer stimulus and checks which frame carries the request.

// File: rtl/usb_frm_pkg.sv
package usb_frm_pkg;
   typedef enum logic [2:0] {
      SEL_IVL    = 3'd0,
      SEL_REM    = 3'd1,
      SEL_FNUM   = 3'd2,
      SEL_PSTART = 3'd3,
      SEL_LSTH   = 3'd4
   } frm_sel_e;
endpackage

// File: rtl/frm_cfg_regs.sv
module frm_cfg_regs
   import usb_frm_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FI_W    = 14,
   parameter int unsigned MPS_W   = 15,
   parameter int unsigned MPS_LSB = 16,
   parameter int unsigned HALF_W  = 16,
   parameter logic [FI_W-1:0]   FI_RST   = 'h2EDF,
   parameter logic [MPS_W-1:0]  MPS_RST  = 'h2778,
   parameter logic [HALF_W-1:0] LSTH_RST = 'h0628
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [FI_W-1:0]   fi,
   output logic [MPS_W-1:0]  fsmps,
   output logic              fit,
   output logic [HALF_W-1:0] pstart,
   output logic [HALF_W-1:0] lsth
);
   logic wr_ivl, wr_pst, wr_lst;

   assign wr_ivl = wr_en && (wr_sel == SEL_IVL);
   assign wr_pst = wr_en && (wr_sel == SEL_PSTART);
   assign wr_lst = wr_en && (wr_sel == SEL_LSTH);

   generate
      if (MPS_LSB > FI_W) begin : g_gap
         logic unused_gap;
         assign unused_gap = ^wr_data[MPS_LSB-1:FI_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fi    <= FI_RST;
         fsmps <= MPS_RST;
         fit   <= 1'b0;
      end else if (wr_ivl) begin
         fi    <= wr_data[FI_W-1:0];
         fsmps <= wr_data[MPS_LSB +: MPS_W];
         fit   <= wr_data[DATA_W-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pstart <= '0;
         lsth   <= LSTH_RST;
      end else begin
         if (wr_pst) pstart <= wr_data[HALF_W-1:0];
         if (wr_lst) lsth   <= wr_data[HALF_W-1:0];
      end
   end
endmodule

// File: rtl/frm_counter.sv
module frm_counter #(
   parameter int unsigned FI_W = 14,
   parameter int unsigned FN_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_tick,
   input  logic            run_en,
   input  logic [FI_W-1:0] fi,
   input  logic            fit,
   output logic [FI_W-1:0] remain,
   output logic            frt,
   output logic [FN_W-1:0] frame_num,
   output logic            sof_pulse,
   output logic            boundary
);
   logic run_q;
   logic start;
   logic load;

   assign start    = run_en && !run_q;
   assign boundary = run_en && run_q && bit_tick && (remain == '0);
   assign load     = start || boundary;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         remain    <= '0;
         frt       <= 1'b0;
         frame_num <= '0;
         sof_pulse <= 1'b0;
      end else begin
         run_q     <= run_en;
         sof_pulse <= load;
         if (load)
            remain <= fi;
         else if (!run_en)
            remain <= '0;
         else if (bit_tick && (remain != '0))
            remain <= remain - 1'b1;
         if (boundary) begin
            frt       <= fit;
            frame_num <= frame_num + 1'b1;
         end
      end
   end
endmodule

// File: rtl/frm_done_delay.sv
module frm_done_delay #(
   parameter int unsigned DLY_W  = 3,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              xfer_done,
   input  logic [DLY_W-1:0]  xfer_delay,
   input  logic              wb_irq_pend,
   input  logic              irq_any,
   input  logic [ADDR_W-1:0] done_head,
   output logic [DLY_W-1:0]  dly_cnt,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_head
);
   localparam logic [DLY_W-1:0] DLY_MAX = '1;

   logic             fire;
   logic [DLY_W-1:0] after_b;
   logic [DLY_W-1:0] cnt_nxt;

   always_comb begin
      fire    = boundary && (dly_cnt == '0) && !wb_irq_pend;
      after_b = dly_cnt;
      if (fire)
         after_b = DLY_MAX;
      else if (boundary && (dly_cnt != DLY_MAX) && (dly_cnt != '0))
         after_b = dly_cnt - 1'b1;
      cnt_nxt = (xfer_done && (xfer_delay < after_b)) ? xfer_delay : after_b;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_cnt <= DLY_MAX;
         wb_req  <= 1'b0;
         wb_head <= '0;
      end else begin
         dly_cnt <= cnt_nxt;
         wb_req  <= fire;
         if (fire)
            wb_head <= {done_head[ADDR_W-1:1], done_head[0] | irq_any};
      end
   end
endmodule

// File: rtl/frm_read_mux.sv
module frm_read_mux
   import usb_frm_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FI_W    = 14,
   parameter int unsigned MPS_W   = 15,
   parameter int unsigned MPS_LSB = 16,
   parameter int unsigned HALF_W  = 16,
   parameter int unsigned FN_W    = 16
) (
   input  logic [2:0]        rd_sel,
   input  logic              run_en,
   input  logic [FI_W-1:0]   fi,
   input  logic [MPS_W-1:0]  fsmps,
   input  logic              fit,
   input  logic [FI_W-1:0]   remain,
   input  logic              frt,
   input  logic [FN_W-1:0]   frame_num,
   input  logic [HALF_W-1:0] pstart,
   input  logic [HALF_W-1:0] lsth,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] ivl_word, rem_word;

   always_comb begin
      ivl_word                      = '0;
      ivl_word[FI_W-1:0]            = fi;
      ivl_word[MPS_LSB +: MPS_W]    = fsmps;
      ivl_word[DATA_W-1]            = fit;
      rem_word                      = '0;
      rem_word[DATA_W-1]            = frt;
      if (run_en)
         rem_word[FI_W-1:0]         = remain;
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_IVL:    rd_data = ivl_word;
         SEL_REM:    rd_data = rem_word;
         SEL_FNUM:   rd_data[FN_W-1:0]   = frame_num;
         SEL_PSTART: rd_data[HALF_W-1:0] = pstart;
         SEL_LSTH:   rd_data[HALF_W-1:0] = lsth;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/usb_frame_clock.sv
module usb_frame_clock #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FI_W    = 14,
   parameter int unsigned MPS_W   = 15,
   parameter int unsigned MPS_LSB = 16,
   parameter int unsigned HALF_W  = 16,
   parameter int unsigned FN_W    = 16,
   parameter int unsigned DLY_W   = 3,
   parameter logic [FI_W-1:0]   FI_RST   = 'h2EDF,
   parameter logic [MPS_W-1:0]  MPS_RST  = 'h2778,
   parameter logic [HALF_W-1:0] LSTH_RST = 'h0628
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              run_en,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic              xfer_done,
   input  logic [DLY_W-1:0]  xfer_delay,
   input  logic              wb_irq_pend,
   input  logic              irq_any,
   input  logic [DATA_W-1:0] done_head,
   output logic              sof_pulse,
   output logic              wb_req,
   output logic [DATA_W-1:0] wb_head
);
   generate
      if (FI_W > MPS_LSB) begin : g_bad_fi
         $error("interval field overlaps max-packet field");
      end
      if (MPS_LSB + MPS_W > DATA_W - 1) begin : g_bad_mps
         $error("max-packet field overlaps toggle bit");
      end
      if ((FN_W > DATA_W) || (HALF_W > DATA_W)) begin : g_bad_half
         $error("read field wider than data word");
      end
   endgenerate

   logic [FI_W-1:0]   fi;
   logic [MPS_W-1:0]  fsmps;
   logic              fit;
   logic [HALF_W-1:0] pstart;
   logic [HALF_W-1:0] lsth;
   logic [FI_W-1:0]   remain;
   logic              frt;
   logic [FN_W-1:0]   frame_num;
   logic              boundary;
   logic [DLY_W-1:0]  dly_cnt;

   frm_cfg_regs #(
      .DATA_W(DATA_W), .FI_W(FI_W), .MPS_W(MPS_W), .MPS_LSB(MPS_LSB),
      .HALF_W(HALF_W), .FI_RST(FI_RST), .MPS_RST(MPS_RST), .LSTH_RST(LSTH_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .fi(fi), .fsmps(fsmps), .fit(fit),
      .pstart(pstart), .lsth(lsth)
   );

   frm_counter #(.FI_W(FI_W), .FN_W(FN_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run_en(run_en),
      .fi(fi), .fit(fit), .remain(remain), .frt(frt),
      .frame_num(frame_num), .sof_pulse(sof_pulse), .boundary(boundary)
   );

   frm_done_delay #(.DLY_W(DLY_W), .ADDR_W(DATA_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .xfer_done(xfer_done),
      .xfer_delay(xfer_delay), .wb_irq_pend(wb_irq_pend), .irq_any(irq_any),
      .done_head(done_head), .dly_cnt(dly_cnt), .wb_req(wb_req),
      .wb_head(wb_head)
   );

   frm_read_mux #(
      .DATA_W(DATA_W), .FI_W(FI_W), .MPS_W(MPS_W), .MPS_LSB(MPS_LSB),
      .HALF_W(HALF_W), .FN_W(FN_W)
   ) u_rd (
      .rd_sel(rd_sel), .run_en(run_en), .fi(fi), .fsmps(fsmps), .fit(fit),
      .remain(remain), .frt(frt), .frame_num(frame_num), .pstart(pstart),
      .lsth(lsth), .rd_data(rd_data)
   );
endmodule

// File: rtl/frm_checker.sv
module frm_checker #(
   parameter int unsigned FI_W  = 14,
   parameter int unsigned FN_W  = 16,
   parameter int unsigned DLY_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             sof_pulse,
   input logic             wb_req,
   input logic             wb_head_lsb,
   input logic             irq_any,
   input logic             xfer_done,
   input logic [FI_W-1:0]  remain,
   input logic             frt,
   input logic [FN_W-1:0]  frame_num,
   input logic [DLY_W-1:0] dly_cnt
);
   localparam logic [DLY_W-1:0] DLY_MAX = '1;

   // R5 / R11: no frame starts unless the operational state was active
   p_sof_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !sof_pulse);

   // R5: the frame number moves only with a start of frame, by one
   p_fnum_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_num) |-> (sof_pulse && (frame_num == FN_W'($past(frame_num) + 1'b1))));

   // R5: the remaining toggle changes only at a frame start
   p_frt_at_sof_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frt) |-> sof_pulse);

   // R4: between loads the count holds or drops by exactly one
   p_remain_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_en) && !sof_pulse) |->
         ((remain == $past(remain)) || (remain == FI_W'($past(remain) - 1'b1))));

   // R7: a writeback request comes with a frame start
   p_wb_with_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> sof_pulse);

   // R7: the delay counter reloads after a writeback
   p_wb_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !$past(xfer_done)) |-> (dly_cnt == DLY_MAX));

   // R8: pending enabled interrupt flags bit 0 of the written head
   p_wb_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && $past(irq_any)) |-> wb_head_lsb);
endmodule

bind usb_frame_clock frm_checker #(.FI_W(FI_W), .FN_W(FN_W), .DLY_W(DLY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .sof_pulse(sof_pulse),
   .wb_req(wb_req), .wb_head_lsb(wb_head[0]), .irq_any(irq_any),
   .xfer_done(xfer_done), .remain(remain), .frt(frt),
   .frame_num(frame_num), .dly_cnt(dly_cnt)
);

// File: tb/sim_usb_frame_clock.sv
module sim_usb_frame_clock;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {select, write data, expected read}
   localparam logic [66:0] VEC [0:NVEC-1] = '{
      {3'd0, 32'hFFFF_FFFF, 32'hFFFF_3FFF},   // R2 interval packing
      {3'd3, 32'h1234_5678, 32'h0000_5678},   // R10 periodic start
      {3'd4, 32'hABCD_9999, 32'h0000_9999},   // R10 low-speed threshold
      {3'd1, 32'hFFFF_FFFF, 32'h0000_0000},   // R3 remaining not writable
      {3'd2, 32'hFFFF_FFFF, 32'h0000_0000},   // R3 frame number not writable
      {3'd0, 32'h1234_5678, 32'h1234_1678}    // R2 interval packing
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0;
   logic        run_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        xfer_done = 1'b0;
   logic [2:0]  xfer_delay = '0;
   logic        wb_irq_pend = 1'b0;
   logic        irq_any = 1'b0;
   logic [31:0] done_head = '0;
   logic        sof_pulse;
   logic        wb_req;
   logic [31:0] wb_head;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_frame_clock u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run_en(run_en),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .xfer_done(xfer_done), .xfer_delay(xfer_delay),
      .wb_irq_pend(wb_irq_pend), .irq_any(irq_any), .done_head(done_head),
      .sof_pulse(sof_pulse), .wb_req(wb_req), .wb_head(wb_head)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_reg(input logic [2:0] sel, output logic [31:0] val);
      rd_sel = sel;
      #1 val = rd_data;
   endtask

   // waits for the next start of frame, returns the writeback flag seen with it
   task automatic wait_sof(output logic got_wb);
      got_wb = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (sof_pulse) begin
            got_wb = wb_req;
            return;
         end
      end
      check("R5 sof timeout", 32'd0, 32'd1);
   endtask

   task automatic pulse_xfer(input logic [2:0] d);
      xfer_done = 1'b1; xfer_delay = d;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic        wb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_reg(3'd0, v); check("R1 interval", v, 32'h2778_2EDF);
      read_reg(3'd4, v); check("R1 lsthresh", v, 32'h0000_0628);
      read_reg(3'd3, v); check("R1 pstart", v, 32'h0);
      read_reg(3'd2, v); check("R1 frame number", v, 32'h0);
      read_reg(3'd1, v); check("R1 remaining", v, 32'h0);
      check("R1 sof idle", {31'd0, sof_pulse}, 32'd0);

      // register vectors
      for (int k = 0; k < NVEC; k++) begin
         write_reg(VEC[k][66:64], VEC[k][63:32]);
         read_reg(VEC[k][66:64], v);
         check($sformatf("R2/R3/R10 vector %0d", k), v, VEC[k][31:0]);
      end

      // short frame: interval 5, toggle 1
      write_reg(3'd0, 32'h8000_0005);
      read_reg(3'd0, v); check("R2 interval toggle", v, 32'h8000_0005);

      // R11 start of operation
      run_en = 1'b1; bit_tick = 1'b1;
      @(negedge clk);
      check("R11 sof on start", {31'd0, sof_pulse}, 32'd1);
      read_reg(3'd1, v); check("R4 reload at start", v, 32'h0000_0005);
      read_reg(3'd2, v); check("R11 frame number unchanged", v, 32'h0);
      @(negedge clk);
      read_reg(3'd1, v); check("R4 decrement", v, 32'h0000_0004);
      bit_tick = 1'b0;
      repeat (3) @(negedge clk);
      read_reg(3'd1, v); check("R4 hold without tick", v, 32'h0000_0004);
      bit_tick = 1'b1;
      repeat (4) @(negedge clk);
      read_reg(3'd1, v); check("R4 reached zero", v, 32'h0);
      bit_tick = 1'b0;
      repeat (3) @(negedge clk);
      read_reg(3'd1, v); check("R4 stays zero", v, 32'h0);
      check("R5 no sof without tick", {31'd0, sof_pulse}, 32'd0);
      bit_tick = 1'b1;
      @(negedge clk);
      check("R5 sof at boundary", {31'd0, sof_pulse}, 32'd1);
      read_reg(3'd1, v); check("R5 toggle copied", v, 32'h8000_0005);
      read_reg(3'd2, v); check("R5 frame number step", v, 32'h1);

      // R3 outside operational
      run_en = 1'b0;
      read_reg(3'd1, v); check("R3 not operational", v, 32'h8000_0000);
      @(negedge clk);
      run_en = 1'b1;
      @(negedge clk);
      check("R11 restart sof", {31'd0, sof_pulse}, 32'd1);
      read_reg(3'd2, v); check("R11 frame number kept", v, 32'h1);

      // R6 / R9 / R7 / R8: delay 2 reports on third boundary
      irq_any = 1'b1; done_head = 32'h0000_1000;
      pulse_xfer(3'd2);
      wait_sof(wb); check("R9 delay 2 frame 1", {31'd0, wb}, 32'd0);
      wait_sof(wb); check("R9 delay 2 frame 2", {31'd0, wb}, 32'd0);
      wait_sof(wb); check("R7 writeback frame 3", {31'd0, wb}, 32'd1);
      check("R8 head flagged", wb_head, 32'h0000_1001);
      wait_sof(wb); check("R9 no step at 7 a", {31'd0, wb}, 32'd0);
      wait_sof(wb); check("R9 no step at 7 b", {31'd0, wb}, 32'd0);

      // R6: larger delay ignored
      irq_any = 1'b0; done_head = 32'h0000_2000;
      pulse_xfer(3'd3);
      pulse_xfer(3'd5);
      wait_sof(wb); check("R6 frame 1", {31'd0, wb}, 32'd0);
      wait_sof(wb); check("R6 frame 2", {31'd0, wb}, 32'd0);
      wait_sof(wb); check("R6 frame 3", {31'd0, wb}, 32'd0);
      wait_sof(wb); check("R6 writeback frame 4", {31'd0, wb}, 32'd1);
      check("R8 head unflagged", wb_head, 32'h0000_2000);

      // R7: pending interrupt blocks writeback
      irq_any = 1'b1; done_head = 32'h0000_3000; wb_irq_pend = 1'b1;
      pulse_xfer(3'd0);
      wait_sof(wb); check("R7 blocked 1", {31'd0, wb}, 32'd0);
      wait_sof(wb); check("R7 blocked 2", {31'd0, wb}, 32'd0);
      wb_irq_pend = 1'b0;
      wait_sof(wb); check("R7 released", {31'd0, wb}, 32'd1);
      check("R8 head after release", wb_head, 32'h0000_3001);

      // R5 frame number wrap, one frame per cycle
      write_reg(3'd0, 32'h0000_0000);
      rd_sel = 3'd2;
      for (int i = 0; i < 70000; i++) begin
         @(negedge clk);
         #1;
         if (rd_data[15:0] == 16'hFFFF) break;
      end
      check("R5 reached top", rd_data, 32'h0000_FFFF);
      @(negedge clk);
      #1;
      check("R5 wrap to zero", rd_data, 32'h0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule